// File: doc/BRIEF.md
# Sensor Row Pixel Readout Timer

This block times the readout of one image row inside a sensor sequencer. A row-start sync opens a readout window: a valid flag goes high on the next clock, and a pair counter advances once per system clock until it matches a programmed limit. Each clock moves two pixels, so the limit is half the window width minus one. During the window the block presents a pair column address that starts at the window's horizontal start position and steps by one each clock. When the window closes, the block emits a single-cycle row-done pulse.

Alongside the readout, a free-running prescaler produces a slow sequencer tick at 4, 8, 16 or 32 system clocks, chosen by a 2-bit select. That tick paces row blanking. It has no effect on the pixel readout rate, which always stays at one pair per system clock. A start position beyond the last legal pair address is clamped. A sync that arrives while a row is being read abandons that row and restarts the window.

Top module: `row_readout_timer`

## Requirements
- R1: After reset, pixValid, rowDone and seqTick are low and colAddr is 0.
- R2: seqTick is a one-cycle pulse repeating every 4 << granSel system clocks (granSel 00 gives 4, 01 gives 8, 10 gives 16, 11 gives 32).
- R3: pixValid is high in the clock cycle that follows a cycle in which rowSync is sampled high.
- R4: After a sync, pixValid stays high for exactly pairCount + 1 consecutive cycles, so that pairCount = window width / 2 − 1. pairCount = 0 gives a single cycle.
- R5: In the first valid cycle, colAddr equals the start position. In each later valid cycle of the same row it is one greater than in the cycle before.
- R6: A start position of 640 or more loads colAddr as 639. Values 0 to 639 load unchanged.
- R7: rowDone is high for one cycle, exactly in the cycle in which pixValid has just fallen after completing a row.
- R8: A rowSync that arrives while pixValid is high restarts the window from the new start position and count. No rowDone is produced for the abandoned row.
- R9: pairCount and xStart are captured at the sync. Changing them during a readout does not affect that row.
- R10: The readout length and the address sequence are the same for every granSel setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (pixel pair rate) |
| rstN | input | 1 | Active-low synchronous reset |
| rowSync | input | 1 | Row-start sync, one cycle |
| granSel | input | 2 | Sequencer tick divide select |
| pairCount | input | 12 | Pair count limit (width/2 − 1) |
| xStart | input | 11 | Window start pair address |
| pixValid | output | 1 | Readout window active |
| colAddr | output | 11 | Current pair column address |
| rowDone | output | 1 | One-cycle end-of-row pulse |
| seqTick | output | 1 | Slow sequencer clock enable |

## Verification
Rows are run with a single-pair window, with a full 640-pixel window and with short windows at ordinary start positions. Together these separate an off-by-one in the count compare from a wrong start load. Start positions of 700 and 2047 show whether clamping is applied to the loaded value only. A second sync in the middle of a row, and a change to the count and start inputs mid-row, show whether the window restarts and whether its parameters are latched at the sync. The tick interval is measured for every divide select, and one row is read out at the slowest select, to show that the readout rate does not depend on the tick divider.

// File: rtl/rowtimer_pkg.sv
package rowtimer_pkg;
  // strobes from control to the datapath
  typedef struct packed {
    logic load;     // capture start position and limit, clear counter
    logic advance;  // step counter and column address
  } dpStrobe_t;
endpackage

// File: rtl/rowtimer_ctrl.sv
module rowtimer_ctrl
  import rowtimer_pkg::*;
#(
  parameter int GRAN_W = 2,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowSync,
  input  logic [GRAN_W-1:0] granSel,
  input  logic              lastPair,
  output dpStrobe_t         strobe,
  output logic              pixValid,
  output logic              rowDone,
  output logic              seqTick
);
  localparam logic [PRE_W-1:0] BASE_DIV = PRE_W'(4);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;

  // prescaler for the slow sequencer tick
  always_comb begin
    preLimit = (BASE_DIV << granSel) - PRE_W'(1);
    seqTick  = (preCnt >= preLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        preCnt <= '0;
    else if (seqTick) preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end

  // readout window control; a sync has priority over the end of a row
  always_comb begin
    strobe.load    = rowSync;
    strobe.advance = pixValid && !rowSync && !lastPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      rowDone  <= 1'b0;
    end else begin
      pixValid <= rowSync || (pixValid && !lastPair);
      rowDone  <= pixValid && lastPair && !rowSync;
    end
  end
endmodule

// File: rtl/rowtimer_dp.sv
module rowtimer_dp
  import rowtimer_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ADDR_W    = 11,
  parameter int START_POS = 640
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_W-1:0]  pairCount,
  input  logic [ADDR_W-1:0] xStart,
  output logic [ADDR_W-1:0] colAddr,
  output logic              lastPair
);
  localparam logic [ADDR_W-1:0] START_MAX = ADDR_W'(START_POS - 1);

  logic [CNT_W-1:0]  pairCnt;
  logic [CNT_W-1:0]  pairLimit;
  logic [ADDR_W-1:0] startClamped;

  always_comb begin
    startClamped = (xStart > START_MAX) ? START_MAX : xStart;
    lastPair     = (pairCnt == pairLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairCnt   <= '0;
      pairLimit <= '0;
      colAddr   <= '0;
    end else if (strobe.load) begin
      pairCnt   <= '0;
      pairLimit <= pairCount;
      colAddr   <= startClamped;
    end else if (strobe.advance) begin
      pairCnt   <= pairCnt + CNT_W'(1);
      colAddr   <= colAddr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/row_readout_timer.sv
module row_readout_timer
  import rowtimer_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ADDR_W    = 11,
  parameter int GRAN_W    = 2,
  parameter int START_POS = 640
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowSync,
  input  logic [GRAN_W-1:0] granSel,
  input  logic [CNT_W-1:0]  pairCount,
  input  logic [ADDR_W-1:0] xStart,
  output logic              pixValid,
  output logic [ADDR_W-1:0] colAddr,
  output logic              rowDone,
  output logic              seqTick
);
  // prescaler wide enough for 4 << max select
  localparam int PRE_W = (1 << GRAN_W) + 3;

  dpStrobe_t strobe;
  logic      lastPair;

  rowtimer_ctrl #(.GRAN_W(GRAN_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowSync(rowSync), .granSel(granSel),
    .lastPair(lastPair), .strobe(strobe), .pixValid(pixValid),
    .rowDone(rowDone), .seqTick(seqTick)
  );

  rowtimer_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .START_POS(START_POS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pairCount(pairCount),
    .xStart(xStart), .colAddr(colAddr), .lastPair(lastPair)
  );
endmodule

// File: rtl/rowtimer_chk.sv
module rowtimer_chk #(
  parameter int ADDR_W    = 11,
  parameter int START_POS = 640
) (
  input logic              clk,
  input logic              rstN,
  input logic              rowSync,
  input logic              pixValid,
  input logic [ADDR_W-1:0] colAddr,
  input logic              rowDone,
  input logic              seqTick
);
  a_r3_valid_after_sync: assert property (@(posedge clk) disable iff (!rstN)
    rowSync |=> pixValid);

  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    rowDone |-> (!pixValid && $past(pixValid)));

  a_r8_no_done_on_restart: assert property (@(posedge clk) disable iff (!rstN)
    rowSync |=> !rowDone);

  a_r6_start_in_range: assert property (@(posedge clk) disable iff (!rstN)
    $past(rowSync) |-> (colAddr <= ADDR_W'(START_POS - 1)));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid) && !$past(rowSync)) |->
      (colAddr == ADDR_W'($past(colAddr) + 1'b1)));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    seqTick |=> !seqTick);
endmodule

bind row_readout_timer rowtimer_chk #(.ADDR_W(ADDR_W), .START_POS(START_POS)) u_chk (
  .clk(clk), .rstN(rstN), .rowSync(rowSync), .pixValid(pixValid),
  .colAddr(colAddr), .rowDone(rowDone), .seqTick(seqTick)
);

// File: tb/tb_row_readout_timer.sv
module tb_row_readout_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rowSync = 1'b0;
  logic [1:0]  granSel = 2'd0;
  logic [11:0] pairCount = '0;
  logic [10:0] xStart = '0;
  logic        pixValid, rowDone, seqTick;
  logic [10:0] colAddr;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  int expDone = 0;
  bit finished = 0;

  row_readout_timer dut (
    .clk(clk), .rstN(rstN), .rowSync(rowSync), .granSel(granSel),
    .pairCount(pairCount), .xStart(xStart), .pixValid(pixValid),
    .colAddr(colAddr), .rowDone(rowDone), .seqTick(seqTick)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops one expected address per valid cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && pixValid) begin
        if (expQ.size() == 0) check(0, "R4 extra valid cycle", 1, 0);
        else begin
          int e;
          e = expQ.pop_front();
          check(colAddr == 11'(e), "R5 colAddr", int'(colAddr), e);
        end
      end
      if (rstN && rowDone) begin
        check(expDone > 0, "R7/R8 unexpected rowDone", 1, expDone);
        check(expQ.size() == 0, "R4 rowDone before all pairs", expQ.size(), 0);
        if (expDone > 0) expDone--;
      end
    end
  end

  function automatic int clampStart(input int xs);
    return (xs > 639) ? 639 : xs;
  endfunction

  // push a full row and start it; returns after the window has closed
  task automatic runRow(input int xs, input int pc);
    for (int i = 0; i <= pc; i++) expQ.push_back((clampStart(xs) + i) % 2048);
    expDone++;
    xStart = 11'(xs); pairCount = 12'(pc); rowSync = 1'b1;
    @(negedge clk);
    rowSync = 1'b0;
    repeat (pc + 3) @(negedge clk);
    check(expQ.size() == 0 && expDone == 0, "R4 row completed", expQ.size(), 0);
    check(!pixValid, "R4 valid low after row", int'(pixValid), 0);
  endtask

  task automatic measureTick(input int g);
    int n;
    granSel = 2'(g);
    do @(negedge clk); while (!seqTick);
    do @(negedge clk); while (!seqTick);
    n = 0;
    do begin @(negedge clk); n++; if (n == 1) check(!seqTick, "R2 single cycle", int'(seqTick), 0); end
    while (!seqTick && n < 100);
    check(n == (4 << g), "R2 tick period", n, 4 << g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!pixValid, "R1 pixValid", int'(pixValid), 0);
    check(!rowDone, "R1 rowDone", int'(rowDone), 0);
    check(!seqTick, "R1 seqTick", int'(seqTick), 0);
    check(colAddr == 0, "R1 colAddr", int'(colAddr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 tick period for each select
    for (int g = 0; g < 4; g++) measureTick(g);
    granSel = 2'd0;

    // R3/R4/R5 basic rows
    xStart = 11'd10; pairCount = 12'd3; rowSync = 1'b1;
    for (int i = 0; i <= 3; i++) expQ.push_back(10 + i);
    expDone++;
    @(negedge clk);
    rowSync = 1'b0;
    check(pixValid, "R3 valid after sync", int'(pixValid), 1);
    repeat (6) @(negedge clk);
    runRow(0, 0);      // R4 single pair
    runRow(0, 319);    // R4 full 640-pixel row
    runRow(320, 7);

    // R6 clamp
    runRow(700, 4);
    runRow(2047, 2);
    runRow(639, 1);

    // R8 restart mid-row: first row shows 5 pairs, then new row
    for (int i = 0; i < 5; i++) expQ.push_back(100 + i);
    for (int i = 0; i <= 3; i++) expQ.push_back(200 + i);
    expDone++;
    xStart = 11'd100; pairCount = 12'd20; rowSync = 1'b1;
    @(negedge clk); rowSync = 1'b0;
    repeat (4) @(negedge clk);
    xStart = 11'd200; pairCount = 12'd3; rowSync = 1'b1;
    @(negedge clk); rowSync = 1'b0;
    repeat (7) @(negedge clk);
    check(expQ.size() == 0 && expDone == 0, "R8 restart row", expQ.size(), 0);

    // R9 inputs changed mid-row are ignored
    for (int i = 0; i <= 5; i++) expQ.push_back(50 + i);
    expDone++;
    xStart = 11'd50; pairCount = 12'd5; rowSync = 1'b1;
    @(negedge clk); rowSync = 1'b0;
    @(negedge clk);
    pairCount = 12'd1; xStart = 11'd400;
    repeat (8) @(negedge clk);
    check(expQ.size() == 0 && expDone == 0, "R9 latched params", expQ.size(), 0);

    // R10 slowest select, same readout
    granSel = 2'd3;
    runRow(30, 9);
    granSel = 2'd1;
    runRow(31, 2);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule